// File: doc/BRIEF.md
# Register Command List Sequencer

This block stores up to eight short programs of register writes and replays any one of them on an internal register bus when asked. A host fills a word-addressed command memory, then writes a list number to start that list. The sequencer walks through the list one command at a time. Each command is a pair of words: an opcode/target word followed by a data word. Every write command becomes one transfer on a valid/ready register bus.

A list stops itself by writing a clear value to the sequencer's own active-control register address. It also stops after its last slot. The host can stop a running list through a dedicated active-control write, or use that same write to replay the most recently selected list from its first command. The host may keep loading the memory while a list runs. The change shows up in any command that has not yet been fetched.

Top module: `cmdSeq`

## Requirements
- R1: After reset `seqActive` and `busValid` are low, and the selected list is list 0.
- R2: A host memory write with `hostMemAddr[1:0]` equal to zero stores the word at word index `hostMemAddr[10:2]`. A write with non-zero low bits changes nothing. List n occupies byte addresses n*256 to n*256+255. Command k of a list sits at byte offset 8k (opcode/address word) and offset 8k+4 (data word).
- R3: A `hostListWe` pulse while inactive selects list `hostListNum` and starts it from command 0. `seqActive` is high from the next cycle.
- R4: In the first word of a command, bits 31:24 hold the opcode and bits 23:0 the target address. Opcode 0x02 issues one bus write with `busAddr` set to the target address and `busData` set to the second word. Commands run in slot order.
- R5: A command whose opcode is not 0x02 is skipped without any bus transfer.
- R6: While `busValid` is high and `busReady` is low, `busValid`, `busAddr` and `busData` hold steady. A transfer completes in a cycle where both are high.
- R7: A write to address 0x020004 with data bit 0 equal to 0 is transferred, and then the sequencer goes inactive. With data bit 0 equal to 1, the write is transferred and the list continues.
- R8: When slot 31 finishes without a terminating write, the sequencer goes inactive after 32 commands.
- R9: A `hostActWe` pulse with `hostActData`=1 while inactive replays the last selected list from command 0.
- R10: A `hostActWe` pulse with `hostActData`=0 while active stops the sequencer. A transfer already presented on the bus completes first, and no further transfer follows.
- R11: List-number and activate writes while active are ignored. They neither restart the list nor change the selected list.
- R12: Host memory writes while active are accepted. A modified command that has not yet been fetched runs with its new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostMemWe | input | 1 | Command memory write strobe |
| hostMemAddr | input | 11 | Byte address of the memory write |
| hostMemData | input | 32 | Word to store |
| hostListWe | input | 1 | Start strobe with list number |
| hostListNum | input | 3 | List to select and start |
| hostActWe | input | 1 | Active-control write strobe |
| hostActData | input | 1 | 1 replays the selected list, 0 stops |
| busAddr | output | 24 | Register bus target address |
| busData | output | 32 | Register bus write data |
| busValid | output | 1 | Register bus write request |
| busReady | input | 1 | Register bus acceptance |
| seqActive | output | 1 | Sequencer is running a list |

## Verification
A mixed list of plain writes, a non-write opcode, a keep-running write to the control address and a terminating write shows whether skipping and self-termination are separate decisions. A full 32-command list with no terminator, run under backpressure while the host rewrites a later command, separates the slot-limit stop from the self-stop and shows when memory is fetched. Start and stop pulses sent while a transfer is stalled show that host control never restarts a list or cuts a pending handshake. Replays after reset and after a run show which list is remembered.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RDCMD, S_RDDAT, S_ISSUE} seqState_e;

  typedef struct packed {
    logic selList;
    logic clrIdx;
    logic incIdx;
    logic latchCmd;
    logic latchDat;
  } seqCtl_t;
endpackage

// File: rtl/cmdseq_dp.sv
module cmdseq_dp
  import cmdseq_pkg::*;
#(
  parameter int LISTS = 8,
  parameter int CMDS = 32,
  parameter int BYTE_AW = 11,
  parameter logic [7:0] OP_PUT = 8'h02,
  parameter logic [23:0] ACT_ADDR = 24'h020004
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostMemWe,
  input  logic [BYTE_AW-1:0]     hostMemAddr,
  input  logic [31:0]            hostMemData,
  input  logic [$clog2(LISTS)-1:0] hostListNum,
  input  seqCtl_t                ctl,
  output logic                   isPut,
  output logic                   isStopWrite,
  output logic                   isLast,
  output logic [23:0]            busAddr,
  output logic [31:0]            busData
);
  localparam int LIST_W = $clog2(LISTS);
  localparam int IDX_W = $clog2(CMDS);
  localparam int WADDR_W = LIST_W + IDX_W + 1;
  localparam int WORDS = 1 << WADDR_W;

  logic [31:0] mem [WORDS];
  logic [LIST_W-1:0] listSel;
  logic [IDX_W-1:0] idx;
  logic [31:0] cmdWord, dataWord;
  logic [WADDR_W-1:0] rdAddr;

  assign rdAddr = {listSel, idx, ctl.latchDat};

  always_ff @(posedge clk) begin
    if (hostMemWe && hostMemAddr[1:0] == 2'b00)
      mem[hostMemAddr[BYTE_AW-1:2]] <= hostMemData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      listSel  <= '0;
      idx      <= '0;
      cmdWord  <= '0;
      dataWord <= '0;
    end else begin
      if (ctl.selList) listSel <= hostListNum;
      if (ctl.clrIdx) idx <= '0;
      else if (ctl.incIdx) idx <= idx + 1'b1;
      if (ctl.latchCmd) cmdWord <= mem[rdAddr];
      if (ctl.latchDat) dataWord <= mem[rdAddr];
    end
  end

  assign isPut = cmdWord[31:24] == OP_PUT;
  assign isStopWrite = (cmdWord[23:0] == ACT_ADDR) && !dataWord[0];
  assign isLast = idx == IDX_W'(CMDS - 1);
  assign busAddr = cmdWord[23:0];
  assign busData = dataWord;
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostListWe,
  input  logic    hostActWe,
  input  logic    hostActData,
  input  logic    busReady,
  input  logic    isPut,
  input  logic    isStopWrite,
  input  logic    isLast,
  input  logic [23:0] busAddr,
  input  logic [31:0] busData,
  output seqCtl_t ctl,
  output logic    busValid,
  output logic    seqActive
);
  seqState_e state, nextState;
  logic stopPend;
  logic clrNow;

  assign clrNow = hostActWe && !hostActData;
  assign busValid = state == S_ISSUE;
  assign seqActive = state != S_IDLE;

  always_comb begin
    ctl = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (hostListWe) begin
          ctl.selList = 1'b1;
          ctl.clrIdx = 1'b1;
          nextState = S_RDCMD;
        end else if (hostActWe && hostActData) begin
          ctl.clrIdx = 1'b1;
          nextState = S_RDCMD;
        end
      end
      S_RDCMD: begin
        ctl.latchCmd = 1'b1;
        nextState = clrNow ? S_IDLE : S_RDDAT;
      end
      S_RDDAT: begin
        ctl.latchDat = 1'b1;
        if (clrNow) nextState = S_IDLE;
        else if (isPut) nextState = S_ISSUE;
        else if (isLast) nextState = S_IDLE;
        else begin
          ctl.incIdx = 1'b1;
          nextState = S_RDCMD;
        end
      end
      S_ISSUE: begin
        if (busReady) begin
          if (isStopWrite || isLast || stopPend || clrNow) nextState = S_IDLE;
          else begin
            ctl.incIdx = 1'b1;
            nextState = S_RDCMD;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      stopPend <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == S_IDLE) stopPend <= 1'b0;
      else if (state == S_ISSUE && clrNow) stopPend <= 1'b1;
    end
  end

  // R3
  start_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!seqActive && hostListWe) |=> seqActive);
  // R5
  only_put_issued_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> isPut);
  // R6
  hold_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busData)));
  // R7
  self_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && isStopWrite) |=> !seqActive);
  // R8
  slot_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && isLast) |=> !seqActive);
endmodule

// File: rtl/cmdSeq.sv
module cmdSeq
  import cmdseq_pkg::*;
#(
  parameter int LISTS = 8,
  parameter int CMDS = 32,
  parameter int BYTE_AW = $clog2(LISTS) + $clog2(CMDS) + 3,
  parameter logic [7:0] OP_PUT = 8'h02,
  parameter logic [23:0] ACT_ADDR = 24'h020004
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     hostMemWe,
  input  logic [BYTE_AW-1:0]       hostMemAddr,
  input  logic [31:0]              hostMemData,
  input  logic                     hostListWe,
  input  logic [$clog2(LISTS)-1:0] hostListNum,
  input  logic                     hostActWe,
  input  logic                     hostActData,
  output logic [23:0]              busAddr,
  output logic [31:0]              busData,
  output logic                     busValid,
  input  logic                     busReady,
  output logic                     seqActive
);
  seqCtl_t ctl;
  logic isPut, isStopWrite, isLast;

  cmdseq_dp #(
    .LISTS(LISTS), .CMDS(CMDS), .BYTE_AW(BYTE_AW),
    .OP_PUT(OP_PUT), .ACT_ADDR(ACT_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .hostMemWe(hostMemWe), .hostMemAddr(hostMemAddr), .hostMemData(hostMemData),
    .hostListNum(hostListNum), .ctl(ctl),
    .isPut(isPut), .isStopWrite(isStopWrite), .isLast(isLast),
    .busAddr(busAddr), .busData(busData)
  );

  cmdseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostListWe(hostListWe), .hostActWe(hostActWe), .hostActData(hostActData),
    .busReady(busReady), .isPut(isPut), .isStopWrite(isStopWrite), .isLast(isLast),
    .busAddr(busAddr), .busData(busData),
    .ctl(ctl), .busValid(busValid), .seqActive(seqActive)
  );
endmodule

// File: tb/cmdSeq_tb_top.sv
module cmdSeq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] ACT = 24'h020004;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostMemWe = 1'b0;
  logic [10:0] hostMemAddr = '0;
  logic [31:0] hostMemData = '0;
  logic hostListWe = 1'b0;
  logic [2:0] hostListNum = '0;
  logic hostActWe = 1'b0;
  logic hostActData = 1'b0;
  logic [23:0] busAddr;
  logic [31:0] busData;
  logic busValid;
  logic busReady = 1'b1;
  logic seqActive;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [23:0] recAddr [64];
  logic [31:0] recData [64];
  int recCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdSeq dut_i (
    .clk(clk), .rstN(rstN),
    .hostMemWe(hostMemWe), .hostMemAddr(hostMemAddr), .hostMemData(hostMemData),
    .hostListWe(hostListWe), .hostListNum(hostListNum),
    .hostActWe(hostActWe), .hostActData(hostActData),
    .busAddr(busAddr), .busData(busData), .busValid(busValid),
    .busReady(busReady), .seqActive(seqActive)
  );

  always @(negedge clk) begin
    if (rstN && busValid && busReady && recCount < 64) begin
      recAddr[recCount] = busAddr;
      recData[recCount] = busData;
      recCount = recCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic memWr(logic [10:0] a, logic [31:0] d);
    @(posedge clk); #1;
    hostMemWe = 1'b1; hostMemAddr = a; hostMemData = d;
    @(posedge clk); #1;
    hostMemWe = 1'b0;
  endtask

  task automatic putCmd(int lst, int k, logic [7:0] op, logic [23:0] a, logic [31:0] d);
    memWr(11'(lst*256 + k*8), {op, a});
    memWr(11'(lst*256 + k*8 + 4), d);
  endtask

  task automatic startList(logic [2:0] n);
    @(posedge clk); #1;
    hostListWe = 1'b1; hostListNum = n;
    @(posedge clk); #1;
    hostListWe = 1'b0;
  endtask

  task automatic actWr(logic v);
    @(posedge clk); #1;
    hostActWe = 1'b1; hostActData = v;
    @(posedge clk); #1;
    hostActWe = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && seqActive; i++) @(negedge clk);
  endtask

  task automatic waitValid();
    for (int i = 0; i < 100 && !busValid; i++) @(negedge clk);
  endtask

  task automatic loadLists();
    putCmd(0, 0, 8'h02, 24'h000040, 32'h11111111);
    putCmd(0, 1, 8'h02, ACT, 32'h0);
    putCmd(3, 0, 8'h02, 24'h000A00, 32'h000000A0);
    putCmd(3, 1, 8'h02, ACT, 32'h1);
    putCmd(3, 2, 8'h07, 24'h000B00, 32'h000000B0);
    putCmd(3, 3, 8'h02, 24'h000C00, 32'h000000C0);
    putCmd(3, 4, 8'h02, ACT, 32'h0);
    putCmd(5, 0, 8'h02, 24'h000005, 32'h00000055);
    putCmd(5, 1, 8'h02, ACT, 32'hFFFFFFFE);
    for (int k = 0; k < 32; k++)
      putCmd(7, k, 8'h02, 24'(32'h100 + k), 32'h70000000 + k);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 seqActive", 32'(seqActive), 32'h0);
    check("R1 busValid", 32'(busValid), 32'h0);
  endtask

  task automatic testDefaultReplay();
    memWr(11'd5, 32'hBADBAD00);
    recCount = 0;
    actWr(1'b1);
    waitIdle();
    @(negedge clk);
    check("R9 replay of list 0 count", 32'(recCount), 32'd2);
    check("R9 list 0 addr", 32'(recAddr[0]), 32'h40);
    check("R2 misaligned write ignored", recData[0], 32'h11111111);
  endtask

  task automatic testMixedList();
    recCount = 0;
    startList(3'd3);
    check("R3 active after start", 32'(seqActive), 32'h1);
    waitIdle();
    @(negedge clk);
    check("R5 skip leaves four transfers", 32'(recCount), 32'd4);
    check("R4 first addr", 32'(recAddr[0]), 32'hA00);
    check("R4 first data", recData[0], 32'hA0);
    check("R7 keep-running write addr", 32'(recAddr[1]), 32'(ACT));
    check("R7 keep-running write data", recData[1], 32'h1);
    check("R5 next after skip", 32'(recAddr[2]), 32'hC00);
    check("R7 stop write data", recData[3], 32'h0);
    check("R7 inactive after stop", 32'(seqActive), 32'h0);
  endtask

  task automatic testIgnoreWhileActive();
    recCount = 0;
    busReady = 1'b0;
    startList(3'd5);
    waitValid();
    startList(3'd3);
    actWr(1'b1);
    @(negedge clk);
    check("R11 still on first command", 32'(busAddr), 32'h5);
    busReady = 1'b1;
    waitIdle();
    @(negedge clk);
    check("R11 no restart count", 32'(recCount), 32'd2);
    check("R7 stop with even data", recData[1], 32'hFFFFFFFE);
    recCount = 0;
    actWr(1'b1);
    waitIdle();
    @(negedge clk);
    check("R11 selection kept count", 32'(recCount), 32'd2);
    check("R9 replays list 5", 32'(recAddr[0]), 32'h5);
  endtask

  task automatic testFullList();
    recCount = 0;
    busReady = 1'b0;
    startList(3'd7);
    waitValid();
    repeat (3) @(negedge clk);
    check("R6 valid held", 32'(busValid), 32'h1);
    check("R6 addr held", 32'(busAddr), 32'h100);
    memWr(11'(7*256 + 5*8 + 4), 32'hDEAD0005);
    @(negedge clk);
    check("R6 no transfer while stalled", 32'(recCount), 32'd0);
    busReady = 1'b1;
    waitIdle();
    @(negedge clk);
    check("R8 32 commands then stop", 32'(recCount), 32'd32);
    check("R8 last addr", 32'(recAddr[31]), 32'h11F);
    check("R12 rewritten data used", recData[5], 32'hDEAD0005);
    check("R4 slot order", recData[6], 32'h70000006);
  endtask

  task automatic testHostStop();
    recCount = 0;
    busReady = 1'b0;
    startList(3'd7);
    waitValid();
    actWr(1'b0);
    @(negedge clk);
    check("R10 pending transfer kept", 32'(busValid), 32'h1);
    busReady = 1'b1;
    waitIdle();
    repeat (4) @(negedge clk);
    check("R10 exactly one transfer", 32'(recCount), 32'd1);
    check("R10 inactive", 32'(seqActive), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    loadLists();
    testDefaultReplay();
    testMixedList();
    testIgnoreWhileActive();
    testFullList();
    testHostStop();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule